// File: doc/BRIEF.md
# Dual Interleaved PWM Generator

This block produces the switching waveforms for two buck converter channels from one free-running carrier counter. Channel 1 drives a synchronous high-side / low-side switch pair. Channel 2 drives a single PWM line into an external gate driver. The second channel's period begins half a period after the first channel's period, which spreads the input current pulses of the two converters over the cycle.

Each channel takes a digital duty word and a soft-start ceiling. The ceiling is meant to ramp up after enable. The effective duty is the smaller of the two values. It is captured only when the channel's own period begins, so a pulse in progress is never cut short or stretched.

On channel 1, each switch turns on only after the opposite switch's gate is reported off through a feedback bit. If that report does not arrive within a bounded number of cycles, both gates are held off and a sticky fault is raised.

Top module: `dual_pwm_interleave`

## Requirements
- R1: Both channels repeat with a period of P = CLK_HZ / SW_HZ clock cycles, so successive rising edges of `pwm2` are exactly P cycles apart.
- R2: The on-time of a channel in cycles is (eff × P) >> DW. An effective duty of all ones gives a 100 % output (always on), and any effective duty giving 0 produces no pulse.
- R3: The effective duty of each channel is the minimum of its duty word and its soft-start ceiling.
- R4: A duty or ceiling change takes effect only at the start of that channel's next period. A pulse already in progress keeps its width.
- R5: The period of channel 2 starts P/2 cycles after the period of channel 1. With equal duties, `pwm2` rises exactly P/2 cycles after `ls_en` falls.
- R6: `hs_en` and `ls_en` are never high in the same cycle.
- R7: Each gate rises only after a cycle in which the opposite gate enable was low and its off-feedback was high. With a feedback delay of one cycle, the high-side is on for on−2 cycles per period and the low-side for P−on−2 cycles.
- R8: The low-side gate is driven for the whole off-interval. At 0 % duty, `ls_en` is high for all P cycles of a period.
- R9: If channel 1 waits GATE_TMO consecutive cycles for gate-off feedback, `gate_fault` goes high and stays high until reset, and both gates stay off. Channel 2 keeps switching.
- R10: During reset, all outputs (`hs_en`, `ls_en`, `pwm2`, `gate_fault`) are low. Reset clears a latched fault.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| duty1 | input | DW | Channel 1 duty command |
| ss1 | input | DW | Channel 1 soft-start ceiling |
| duty2 | input | DW | Channel 2 duty command |
| ss2 | input | DW | Channel 2 soft-start ceiling |
| hs_off_fb | input | 1 | High-side gate sensed off |
| ls_off_fb | input | 1 | Low-side gate sensed off |
| hs_en | output | 1 | High-side gate enable |
| ls_en | output | 1 | Low-side gate enable |
| pwm2 | output | 1 | Channel 2 PWM output |
| gate_fault | output | 1 | Sticky gate handoff timeout |

## Verification
A new duty word is captured at the next period start of its channel. After that, `pwm2` follows the carrier phase one register later. A channel 1 gate follows its demand one register later, plus the feedback delay and one more register for the handoff. For this reason, the bench waits three full periods after every command change. It then measures whole pulse widths and whole-period high counts, not single edge times, so the expected values do not depend on where in the period a command arrived. The two cases that rely on exact timing are the mid-pulse duty change and the half-period offset. Both are measured relative to an observed edge of an output, never relative to the moment the input changed.

// File: rtl/dual_pwm_interleave.sv
module dual_pwm_interleave #(
  parameter int CLK_HZ   = 50_000_000,
  parameter int SW_HZ    = 250_000,
  parameter int DW       = 8,
  parameter int GATE_TMO = 64,
  localparam int PERIOD  = CLK_HZ / SW_HZ,
  localparam int HALF    = PERIOD / 2,
  localparam int CW      = $clog2(PERIOD + 1),
  localparam int TW      = $clog2(GATE_TMO + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [DW-1:0] duty1,
  input  logic [DW-1:0] ss1,
  input  logic [DW-1:0] duty2,
  input  logic [DW-1:0] ss2,
  input  logic          hs_off_fb,
  input  logic          ls_off_fb,
  output logic          hs_en,
  output logic          ls_en,
  output logic          pwm2,
  output logic          gate_fault
);

  function automatic logic [CW-1:0] on_time(input logic [DW-1:0] d, input logic [DW-1:0] s);
    logic [DW-1:0]    eff;
    logic [DW+CW-1:0] prod;
    eff  = (d < s) ? d : s;
    prod = (DW+CW)'(eff) * (DW+CW)'(PERIOD);
    if (&eff) return CW'(PERIOD);
    return CW'(prod >> DW);
  endfunction

  logic [CW-1:0] cnt, p2, on1_q, on2_q;
  logic [TW-1:0] wcnt;
  logic dem1, dem2, waiting, timeout;

  assign p2   = (cnt >= CW'(HALF)) ? cnt - CW'(HALF) : cnt + CW'(PERIOD - HALF);
  assign dem1 = cnt < on1_q;
  assign dem2 = p2 < on2_q;

  assign waiting = dem1 ? (!hs_en && !(!ls_en && ls_off_fb))
                        : (!ls_en && !(!hs_en && hs_off_fb));
  assign timeout = waiting && (wcnt == TW'(GATE_TMO - 1));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt   <= '0;
      on1_q <= '0;
      on2_q <= '0;
      pwm2  <= 1'b0;
    end else begin
      cnt  <= (cnt == CW'(PERIOD - 1)) ? '0 : cnt + 1'b1;
      if (cnt == CW'(PERIOD - 1)) on1_q <= on_time(duty1, ss1);
      if (cnt == CW'(HALF - 1))   on2_q <= on_time(duty2, ss2);
      pwm2 <= dem2;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        wcnt <= '0;
    else if (!waiting) wcnt <= '0;
    else if (!timeout) wcnt <= wcnt + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hs_en      <= 1'b0;
      ls_en      <= 1'b0;
      gate_fault <= 1'b0;
    end else if (gate_fault || timeout) begin
      hs_en      <= 1'b0;
      ls_en      <= 1'b0;
      gate_fault <= 1'b1;
    end else if (dem1) begin
      ls_en <= 1'b0;
      if (!ls_en && ls_off_fb) hs_en <= 1'b1;
    end else begin
      hs_en <= 1'b0;
      if (!hs_en && hs_off_fb) ls_en <= 1'b1;
    end
  end

endmodule

// File: rtl/dual_pwm_interleave_chk.sv
module dual_pwm_interleave_chk #(
  parameter int CW   = 8,
  parameter int HALF = 100
) (
  input logic          clk,
  input logic          rst_n,
  input logic          hs_en,
  input logic          ls_en,
  input logic          hs_off_fb,
  input logic          ls_off_fb,
  input logic          gate_fault,
  input logic [CW-1:0] cnt,
  input logic [CW-1:0] on1_q,
  input logic [CW-1:0] on2_q
);

  a_r6_no_overlap: assert property (@(posedge clk) disable iff (!rst_n)
    !(hs_en && ls_en));

  a_r7_hs_after_fb: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(hs_en) |-> ($past(ls_off_fb) && !$past(ls_en)));

  a_r7_ls_after_fb: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(ls_en) |-> ($past(hs_off_fb) && !$past(hs_en)));

  a_r9_fault_gates_off: assert property (@(posedge clk) disable iff (!rst_n)
    gate_fault |-> (!hs_en && !ls_en));

  a_r9_fault_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    gate_fault |=> gate_fault);

  a_r4_ch1_load_at_start: assert property (@(posedge clk) disable iff (!rst_n)
    (cnt != '0) |-> $stable(on1_q));

  a_r4_ch2_load_at_start: assert property (@(posedge clk) disable iff (!rst_n)
    (cnt != CW'(HALF)) |-> $stable(on2_q));

endmodule

bind dual_pwm_interleave dual_pwm_interleave_chk #(.CW(CW), .HALF(HALF)) u_chk (
  .clk(clk), .rst_n(rst_n), .hs_en(hs_en), .ls_en(ls_en),
  .hs_off_fb(hs_off_fb), .ls_off_fb(ls_off_fb), .gate_fault(gate_fault),
  .cnt(cnt), .on1_q(on1_q), .on2_q(on2_q)
);

// File: tb/dual_pwm_interleave_tb.sv
`timescale 1ns/1ps
module dual_pwm_interleave_tb;
  localparam int DW = 8;
  localparam int P  = 64;
  localparam int H  = 32;

  logic clk = 1'b0;
  logic rst_n;
  logic [DW-1:0] duty1, ss1, duty2, ss2;
  logic hs_en, ls_en, pwm2, gate_fault;
  logic hs_fb_q, ls_fb_q, stuck;
  logic hs_off_fb, ls_off_fb;

  int n_run = 0, n_fail = 0, cyc = 0;
  int exp_q[$];
  string tag_q[$];

  always #2 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin hs_fb_q <= 1'b1; ls_fb_q <= 1'b1; end
    else begin hs_fb_q <= ~hs_en; ls_fb_q <= ~ls_en; end
  end
  assign hs_off_fb = hs_fb_q;
  assign ls_off_fb = ls_fb_q & ~stuck;

  dual_pwm_interleave #(.CLK_HZ(16_000_000), .SW_HZ(250_000), .DW(DW), .GATE_TMO(16)) u_dut (
    .clk(clk), .rst_n(rst_n), .duty1(duty1), .ss1(ss1), .duty2(duty2), .ss2(ss2),
    .hs_off_fb(hs_off_fb), .ls_off_fb(ls_off_fb),
    .hs_en(hs_en), .ls_en(ls_en), .pwm2(pwm2), .gate_fault(gate_fault));

  task automatic check(input string req, input int act, input int exp);
    n_run++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // monitor: pops expected pwm2 pulse widths
  logic m_prev = 1'b0;
  int   m_rise = 0;
  always @(negedge clk) begin
    if (pwm2 && !m_prev) m_rise = cyc;
    if (!pwm2 && m_prev && exp_q.size() != 0)
      check(tag_q.pop_front(), cyc - m_rise, exp_q.pop_front());
    m_prev = pwm2;
  end

  task automatic push(input string tag, input int w);
    exp_q.push_back(w);
    tag_q.push_back(tag);
  endtask

  task automatic drain();
    while (exp_q.size() != 0) @(negedge clk);
  endtask

  task automatic settle();
    repeat (3*P) @(negedge clk);
  endtask

  task automatic count_win(output int h, output int l, output int p);
    h = 0; l = 0; p = 0;
    repeat (P) begin
      @(negedge clk);
      h += int'(hs_en); l += int'(ls_en); p += int'(pwm2);
    end
  endtask

  task automatic wait_pwm2_rise(output int at);
    logic p = pwm2;
    forever begin
      @(negedge clk);
      if (pwm2 && !p) break;
      p = pwm2;
    end
    at = cyc;
  endtask

  task automatic wait_ls_fall(output int at);
    logic p = ls_en;
    forever begin
      @(negedge clk);
      if (!ls_en && p) break;
      p = ls_en;
    end
    at = cyc;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog actual=hung expected=done");
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    int h, l, p, a, b;
    rst_n = 1'b0; stuck = 1'b0;
    duty1 = '0; duty2 = '0; ss1 = '1; ss2 = '1;
    repeat (3) @(negedge clk);
    check("R10 hs_en in reset", int'(hs_en), 0);
    check("R10 ls_en in reset", int'(ls_en), 0);
    check("R10 pwm2 in reset", int'(pwm2), 0);
    check("R10 gate_fault in reset", int'(gate_fault), 0);
    rst_n = 1'b1;

    settle(); count_win(h, l, p);
    check("R8 ls high at 0%", l, P);
    check("R8 hs low at 0%", h, 0);

    duty1 = 8'd255; settle(); count_win(h, l, p);
    check("R2 hs at 100%", h, P);
    check("R2 ls at 100%", l, 0);

    duty1 = 8'd128; settle(); count_win(h, l, p);
    check("R7 hs on-time minus handoff", h, 30);
    check("R7 ls off-time minus handoff", l, 30);

    duty1 = 8'd200; ss1 = 8'd100; settle(); count_win(h, l, p);
    check("R3 hs clamped by ss1", h, 23);
    check("R3 ls clamped by ss1", l, 37);
    ss1 = '1; duty1 = 8'd128;

    duty2 = 8'd128; settle();
    push("R2 pwm2 width duty 128", 32); drain();
    wait_pwm2_rise(a); wait_pwm2_rise(b);
    check("R1 pwm2 period", b - a, P);

    wait_ls_fall(a); wait_pwm2_rise(b);
    check("R5 half period offset", b - a, H);

    wait_pwm2_rise(a);
    duty2 = 8'd200;
    push("R4 pulse in progress keeps width", 32);
    push("R4 next period new width", 50);
    drain();

    duty2 = 8'd255; ss2 = 8'd40; settle();
    push("R3 pwm2 clamped by ss2", 10); drain();
    ss2 = '1;

    duty2 = 8'd9; settle();
    push("R2 pwm2 short pulse", 2); drain();

    duty2 = 8'd1; settle(); count_win(h, l, p);
    check("R2 pwm2 no pulse when on-time 0", p, 0);
    duty2 = 8'd255; settle(); count_win(h, l, p);
    check("R2 pwm2 always high at 100%", p, P);
    duty2 = 8'd0; settle(); count_win(h, l, p);
    check("R2 pwm2 low at 0%", p, 0);

    duty2 = 8'd128; settle();
    stuck = 1'b1;
    repeat (2*P) @(negedge clk);
    check("R9 fault raised", int'(gate_fault), 1);
    check("R9 hs off on fault", int'(hs_en), 0);
    check("R9 ls off on fault", int'(ls_en), 0);
    stuck = 1'b0;
    push("R9 ch2 keeps running", 32); drain();
    count_win(h, l, p);
    check("R9 fault sticky", int'(gate_fault), 1);
    check("R9 gates stay off", h + l, 0);

    rst_n = 1'b0;
    repeat (2) @(negedge clk);
    check("R10 reset clears fault", int'(gate_fault), 0);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);

    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule